// File: doc/BRIEF.md
# Calibration Test-Mode Convert Burst Generator

This block drives the front-end control lines of a multiplexed analog readout chain while the system runs in calibration test mode. Software writes a four-bit test control word; one bit enables test mode, and three others set the clock, shift-in and test-pulse lines to the front-end chips directly. The lines change on the clock edge that takes the write, with no internal sequencing.

A rising edge on the test-pulse line, made by a control write, launches a timed burst of convert pulses toward the digitizer cards. A programmed delay comes first. The pulse width and the repetition period come from the same timing parameters that the normal readout sequence uses. While test mode is active, the block also blocks the normal-sequence hold and busy signals and the trigger-acceptance path.

The block assumes a 10 ns clock. Every time value is counted in cycles of that clock, and one timing unit of 20 ns equals two cycles. All levels are active high here. Polarity conversion belongs to the pad logic.

Top module: `tm_convert_burst`

## Requirements
- R1: After reset, test mode is off. Bit 0 of a control write selects test mode, and `test_on` shows that bit from the cycle after the write edge.
- R2: Control-word bit 1 drives `fe_clock`, bit 2 drives `fe_shift` and bit 3 drives `fe_tpulse`. Each line takes its bit from the cycle after the write edge, but only when bit 0 of the same write is 1; otherwise all three lines are 0. After reset all three are 0.
- R3: A write with bits 0 and 3 set, made while `fe_tpulse` is 0, starts a burst. `conv_out` first rises 15 + 2·T5 cycles after that write edge. A T5 value below 2 is treated as 2.
- R4: Each convert pulse is high for 2·T3 cycles, and pulses repeat every 2 + 2·T4 cycles. T4 = 0 is treated as 1, and T3 is held within 1..T4.
- R5: A burst contains exactly N pulses, with N taken from `num_conv`. N = 0 produces no pulse.
- R6: While test mode is on, `hold_out`, `busy_out` and `trig_ok` are 0. While it is off, they follow `seq_hold`, `seq_busy` and `trig_raw`.
- R7: A new test-pulse rising edge during a burst is ignored. The burst in progress keeps its timing and pulse count.
- R8: A control write with bit 0 clear ends any burst. `conv_out` is 0 from the next cycle on, and all level outputs return to 0.
- R9: T3, T4, T5 and N are captured when a burst starts. Changing them during the burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control-word write strobe |
| cfg_data | input | 4 | Control word: [0] mode, [1] clock, [2] shift, [3] test pulse |
| num_conv | input | 11 | Number of convert pulses per burst |
| t3_val | input | 8 | Pulse width, in 20 ns units |
| t4_val | input | 9 | Period minus 20 ns, in 20 ns units |
| t5_val | input | 9 | Delay minus 150 ns, in 20 ns units |
| trig_raw | input | 1 | Trigger request from the normal path |
| seq_hold | input | 1 | Hold from the normal sequencer |
| seq_busy | input | 1 | Busy from the normal sequencer |
| test_on | output | 1 | Test mode active |
| fe_clock | output | 1 | Front-end clock level |
| fe_shift | output | 1 | Front-end shift-in level |
| fe_tpulse | output | 1 | Front-end test pulse level |
| conv_out | output | 1 | Convert pulse |
| trig_ok | output | 1 | Gated trigger acceptance |
| hold_out | output | 1 | Gated hold |
| busy_out | output | 1 | Gated busy |

## Verification
A wrong burst state shows at `conv_out` within one pulse period. Examples are a lost pulse count, a stale captured width, or a restart on a second edge. Each of these moves an edge, adds or removes a pulse, or leaves the line high. For this reason the bench compares `conv_out` with a computed waveform on every cycle of each burst. It does not check only the first edge. A mode register in the wrong state shows in the next cycle on `test_on` and on the three gated normal-path outputs. A retained level bit shows on the front-end lines right after a mode-off write.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2,
    ST_GAP   = 2'd3
  } burst_st_e;

  localparam int DLY_BASE_CYC = 15;  // fixed 150 ns lead at 10 ns/cycle
  localparam int UNIT_CYC     = 2;   // one 20 ns unit in cycles
endpackage

// File: rtl/tmb_test_reg.sv
module tmb_test_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [3:0] data,
  output logic       mode,
  output logic       lv_clk,
  output logic       lv_shift,
  output logic       lv_tp,
  output logic       start,
  output logic       abort
);
  logic       mode_q, mode_d;
  logic [2:0] lv_q, lv_d;

  always_comb begin
    mode_d = mode_q;
    lv_d   = lv_q;
    if (wr) begin
      mode_d = data[0];
      lv_d   = data[3:1] & {3{data[0]}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      lv_q   <= 3'b000;
    end else if (wr) begin
      mode_q <= mode_d;
      lv_q   <= lv_d;
    end
  end

  assign start    = wr & data[0] & data[3] & ~lv_q[2];
  assign abort    = wr & ~data[0];
  assign mode     = mode_q;
  assign lv_clk   = lv_q[0];
  assign lv_shift = lv_q[1];
  assign lv_tp    = lv_q[2];

  // R2: no level may stay up once test mode is off
  p_lvl_needs_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (lv_q == 3'b000));
  // R1: the mode register takes the written bit
  p_mode_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mode == $past(data[0])));
endmodule

// File: rtl/tmb_timing.sv
module tmb_timing #(
  parameter int T3_W  = 8,
  parameter int T4_W  = 9,
  parameter int T5_W  = 9,
  parameter int CNT_W = 12
) (
  input  logic [T3_W-1:0]  t3,
  input  logic [T4_W-1:0]  t4,
  input  logic [T5_W-1:0]  t5,
  output logic [CNT_W-1:0] dly_cyc,
  output logic [CNT_W-1:0] wid_cyc,
  output logic [CNT_W-1:0] gap_cyc
);
  import tmb_pkg::*;

  logic [CNT_W-1:0] t3x, t4x, t5x;

  always_comb begin
    t4x = CNT_W'(t4);
    if (t4x == '0) t4x = CNT_W'(1);
    t3x = CNT_W'(t3);
    if (t3x == '0) t3x = CNT_W'(1);
    if (t3x > t4x) t3x = t4x;
    t5x = CNT_W'(t5);
    if (t5x < CNT_W'(2)) t5x = CNT_W'(2);
    dly_cyc = CNT_W'(DLY_BASE_CYC) + CNT_W'(UNIT_CYC) * t5x;
    wid_cyc = CNT_W'(UNIT_CYC) * t3x;
    gap_cyc = CNT_W'(UNIT_CYC) + CNT_W'(UNIT_CYC) * (t4x - t3x);
  end
endmodule

// File: rtl/tmb_burst_fsm.sv
module tmb_burst_fsm #(
  parameter int CNT_W = 12,
  parameter int N_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] dly_cyc,
  input  logic [CNT_W-1:0] wid_cyc,
  input  logic [CNT_W-1:0] gap_cyc,
  input  logic [N_W-1:0]   n_conv,
  output logic             conv
);
  import tmb_pkg::*;

  burst_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, wid_q, wid_d, gap_q, gap_d;
  logic [N_W-1:0]   left_q, left_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    wid_d  = wid_q;
    gap_d  = gap_q;
    if (abort) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      left_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start && n_conv != '0) begin
          st_d   = ST_DELAY;
          cnt_d  = dly_cyc - CNT_W'(1);
          left_d = n_conv;
          wid_d  = wid_cyc;
          gap_d  = gap_cyc;
        end
        ST_DELAY: if (cnt_q == '0) begin
          st_d  = ST_PULSE;
          cnt_d = wid_q - CNT_W'(1);
        end else cnt_d = cnt_q - CNT_W'(1);
        ST_PULSE: if (cnt_q == '0) begin
          left_d = left_q - N_W'(1);
          if (left_q == N_W'(1)) st_d = ST_IDLE;
          else begin
            st_d  = ST_GAP;
            cnt_d = gap_q - CNT_W'(1);
          end
        end else cnt_d = cnt_q - CNT_W'(1);
        ST_GAP: if (cnt_q == '0) begin
          st_d  = ST_PULSE;
          cnt_d = wid_q - CNT_W'(1);
        end else cnt_d = cnt_q - CNT_W'(1);
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      wid_q  <= '0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      wid_q  <= wid_d;
      gap_q  <= gap_d;
    end
  end

  assign conv = (st_q == ST_PULSE);

  // R7: a burst in flight never gains pulses
  p_no_count_gain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !abort) |=> (left_q <= $past(left_q)));
  // R8: abort lands in idle
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st_q == ST_IDLE));
  // R4: pulse counter stays within captured width
  p_pulse_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PULSE) |-> (cnt_q < wid_q));
  // R5: active burst always has pulses left
  p_left_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (left_q != '0));
endmodule

// File: rtl/tm_convert_burst.sv
module tm_convert_burst #(
  parameter int N_W  = 11,
  parameter int T3_W = 8,
  parameter int T4_W = 9,
  parameter int T5_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [3:0]      cfg_data,
  input  logic [N_W-1:0]  num_conv,
  input  logic [T3_W-1:0] t3_val,
  input  logic [T4_W-1:0] t4_val,
  input  logic [T5_W-1:0] t5_val,
  input  logic            trig_raw,
  input  logic            seq_hold,
  input  logic            seq_busy,
  output logic            test_on,
  output logic            fe_clock,
  output logic            fe_shift,
  output logic            fe_tpulse,
  output logic            conv_out,
  output logic            trig_ok,
  output logic            hold_out,
  output logic            busy_out
);
  localparam int TW_MAX = (T4_W > T5_W) ? T4_W : T5_W;
  localparam int CNT_W  = TW_MAX + 3;

  logic             mode, start, abort;
  logic [CNT_W-1:0] dly_cyc, wid_cyc, gap_cyc;

  tmb_test_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .data(cfg_data),
    .mode(mode), .lv_clk(fe_clock), .lv_shift(fe_shift), .lv_tp(fe_tpulse),
    .start(start), .abort(abort)
  );

  tmb_timing #(.T3_W(T3_W), .T4_W(T4_W), .T5_W(T5_W), .CNT_W(CNT_W)) u_tim (
    .t3(t3_val), .t4(t4_val), .t5(t5_val),
    .dly_cyc(dly_cyc), .wid_cyc(wid_cyc), .gap_cyc(gap_cyc)
  );

  tmb_burst_fsm #(.CNT_W(CNT_W), .N_W(N_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .dly_cyc(dly_cyc), .wid_cyc(wid_cyc), .gap_cyc(gap_cyc),
    .n_conv(num_conv), .conv(conv_out)
  );

  assign test_on  = mode;
  assign trig_ok  = trig_raw & ~mode;
  assign hold_out = seq_hold & ~mode;
  assign busy_out = seq_busy & ~mode;

  // R6: normal-path signals are silent in test mode
  p_mode_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    test_on |-> !(hold_out || busy_out || trig_ok));
  // R1/R8: converts only while test mode is on
  p_conv_in_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_out |-> test_on);
endmodule

// File: tb/tm_convert_burst_tb.sv
module tm_convert_burst_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [3:0]  cfg_data;
  logic [10:0] num_conv;
  logic [7:0]  t3_val;
  logic [8:0]  t4_val, t5_val;
  logic        trig_raw, seq_hold, seq_busy;
  logic test_on, fe_clock, fe_shift, fe_tpulse, conv_out, trig_ok, hold_out, busy_out;

  int n_pass = 0;
  int n_tot  = 0;

  always #10 clk = ~clk;

  tm_convert_burst u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // kind: 0 none, 1 re-edge, 2 abort, 3 parameter change at cycle poke
  task automatic burst(input int t3, input int t4, input int t5, input int n,
                       input int poke, input int kind, input string req);
    int t4e, t3e, t5e, d, w, p, len, bad, first;
    t4e = (t4 == 0) ? 1 : t4;
    t3e = (t3 == 0) ? 1 : t3;
    if (t3e > t4e) t3e = t4e;
    t5e = (t5 < 2) ? 2 : t5;
    d = 15 + 2 * t5e; w = 2 * t3e; p = 2 + 2 * t4e;
    len = d + n * p + 12;
    bad = 0; first = -1;
    t3_val = 8'(t3); t4_val = 9'(t4); t5_val = 9'(t5); num_conv = 11'(n);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = 4'b1001;
    @(posedge clk);
    for (int k = 0; k < len; k++) begin
      bit exp;
      @(negedge clk);
      exp = (k >= d) && (((k - d) % p) < w) && (((k - d) / p) < n);
      if (kind == 2 && k > poke) exp = 1'b0;
      if (conv_out !== exp) bad++;
      if (conv_out === 1'b1 && first < 0) first = k;
      cfg_wr = 1'b0;
      if (kind == 1 && k == poke)     begin cfg_wr = 1'b1; cfg_data = 4'b0001; end
      if (kind == 1 && k == poke + 1) begin cfg_wr = 1'b1; cfg_data = 4'b1001; end
      if (kind == 2 && k == poke)     begin cfg_wr = 1'b1; cfg_data = 4'b1110; end
      if (kind == 3 && k == poke)     begin
        t3_val = 8'd7; t4_val = 9'd9; num_conv = 11'd9; t5_val = 9'd40;
      end
    end
    chk(bad == 0, req, bad, 0);
    if (kind != 2 && n > 0) chk(first == d, "R3 first convert", first, d);
    if (kind == 2)
      chk({test_on, fe_clock, fe_shift, fe_tpulse} == 4'b0, "R8 levels after abort",
          int'({test_on, fe_clock, fe_shift, fe_tpulse}), 0);
    wr(4'b0000);
  endtask

  task automatic t_reset;
    chk({test_on, fe_clock, fe_shift, fe_tpulse, conv_out} == 5'b0, "R1 reset outputs",
        int'({test_on, fe_clock, fe_shift, fe_tpulse, conv_out}), 0);
  endtask

  task automatic t_levels;
    // bits 1 and 2 up with mode: no test-pulse edge
    @(negedge clk); cfg_wr = 1'b1; cfg_data = 4'b0111;
    @(posedge clk); #1;
    chk({test_on, fe_clock, fe_shift, fe_tpulse} == 4'b1110, "R2 levels follow write",
        int'({test_on, fe_clock, fe_shift, fe_tpulse}), 14);
    chk(test_on == 1'b1, "R1 mode bit", int'(test_on), 1);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = 4'b1100;
    @(posedge clk); #1;
    chk({test_on, fe_clock, fe_shift, fe_tpulse} == 4'b0, "R2 levels dropped without mode",
        int'({test_on, fe_clock, fe_shift, fe_tpulse}), 0);
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic t_gating;
    trig_raw = 1'b1; seq_hold = 1'b1; seq_busy = 1'b1;
    @(negedge clk);
    chk({trig_ok, hold_out, busy_out} == 3'b111, "R6 pass-through in normal mode",
        int'({trig_ok, hold_out, busy_out}), 7);
    wr(4'b0001);
    chk({trig_ok, hold_out, busy_out} == 3'b000, "R6 blocked in test mode",
        int'({trig_ok, hold_out, busy_out}), 0);
    wr(4'b0000);
    trig_raw = 1'b0; seq_hold = 1'b0; seq_busy = 1'b0;
  endtask

  task automatic t_zero;
    burst(2, 2, 2, 0, 0, 0, "R5 zero pulses");
  endtask

  initial begin
    #(20 * 200000);
    n_tot++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_data = 4'b0;
    num_conv = '0; t3_val = '0; t4_val = '0; t5_val = '0;
    trig_raw = 1'b0; seq_hold = 1'b0; seq_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_gating();
    burst(1, 2, 2, 3, 0, 0, "R4 basic burst");
    burst(3, 4, 5, 2, 0, 0, "R4 wider burst");
    burst(4, 4, 2, 2, 0, 0, "R4 width equals period-2");
    burst(9, 3, 0, 2, 0, 0, "R4 clamped T3/T5");
    t_zero();
    burst(2, 3, 3, 4, 28, 1, "R7 re-edge ignored");
    burst(2, 3, 3, 4, 30, 2, "R8 abort mid-burst");
    burst(2, 3, 3, 3, 20, 3, "R9 parameters captured");
    burst(1, 1, 2, 5, 0, 0, "R5 five pulses");
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end
endmodule